// File: doc/BRIEF.md
# Display Frame Descriptor Fetcher

This block walks the descriptor chains of a set of display DMA channels (seven by default) once per frame. A `frame_start` pulse starts a pass. The block then visits the channels from the lowest number to the highest. For each enabled channel it works out the address of the next descriptor, checks that the whole 16-byte descriptor lies inside a configured memory window, and reads its four 32-bit words over a word-read port that uses a request/acknowledge handshake. The words are stored in this order: the link to the following descriptor, the frame source address, the frame identifier and the command word. The command word is kept exactly as it was read, for the pixel engine downstream. The block does not move pixel data.

Each channel also has a branch register. Software uses it to send the chain to a different descriptor for exactly one frame, and it can ask for a branch-status event when that jump happens. After the fetch step the block checks the frame source address of each enabled channel. If that address is zero or lies outside the window, the block raises a bus-error event tagged with the channel number. Software reads and writes all per-channel state through a simple address/data register bus. A read has one cycle of latency.

Top module: `fdf_top`

## Requirements
- R1: After reset, every stored register reads as zero, `busy`, `mem_req`, `frame_done`, `evt_bs` and `evt_ber` are low, and mapped reads return `reg_err` low.
- R2: Channel c has four words at byte offset 0x200 + 16*c: word offset 0x0 holds the next-descriptor link, 0x4 the source address, 0x8 the frame ID and 0xC the command. A write to offset 0x0 stores the data ANDed with 0xFFFFFFF0. Writes to 0x4, 0x8 and 0xC are ignored. The branch register of channel c is at offset 0x100 + 4*c, and a write to it stores the data ANDed with 0xFFFFFFF3.
- R3: A read returns its data in the cycle after `reg_rd`. A read of any other offset returns zero and raises `reg_err` for that one cycle. Mapped reads leave `reg_err` low.
- R4: For an enabled channel with no branch pending, the block reads the words at pointer+0, +4, +8 and +0xC, where the pointer is the stored link. It stores them as link, source, ID and command. `mem_addr` is held steady while a request is waiting for its acknowledge.
- R5: Channels are visited in ascending order, and the memory accesses of a pass follow that order. A disabled channel (`chan_en` bit low) causes no memory access, and its source address is set to zero.
- R6: If bit 0 (branch-active) of a channel's branch register is set when the channel is visited, the descriptor is fetched from the address in bits 31:4, with the low four bits zero. Bit 0 is then cleared and the other bits are kept, so the frame after that follows the stored link again.
- R7: If bits 0 and 1 (branch-interrupt) are both set when the channel is visited, `evt_bs` pulses for one cycle with `evt_chan` equal to the channel number. The event is raised even if the branch target is later rejected. If bit 1 is set without bit 0, no event is raised.
- R8: A descriptor pointer P is accepted only if P >= base and P+16 <= base+size. A rejected descriptor causes no memory access. The source address of that frame stays zero, and the link, ID and command registers keep their values.
- R9: After the fetch step of an enabled channel, if the source address is zero or does not satisfy base <= S < base+size, `evt_ber` pulses for one cycle with `evt_chan` equal to the channel number. `evt_bs` and `evt_ber` are never high in the same cycle.
- R10: `busy` is high from the cycle after an accepted `frame_start` until the pass ends. `frame_done` pulses once, with `busy` low, when the last channel has been handled. A `frame_start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW (12) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| reg_err | output | 1 | Unmapped-read flag, one cycle after `reg_rd` |
| chan_en | input | NCH (7) | Per-channel enable |
| frame_start | input | 1 | Starts a descriptor pass |
| busy | output | 1 | A pass is in progress |
| frame_done | output | 1 | One-cycle pulse at the end of a pass |
| mem_req | output | 1 | Memory word-read request |
| mem_addr | output | 32 | Memory byte address |
| mem_ack | input | 1 | Memory acknowledge, with `mem_rdata` valid |
| mem_rdata | input | 32 | Memory read data |
| evt_bs | output | 1 | Branch-status event pulse |
| evt_ber | output | 1 | Bus-error event pulse |
| evt_chan | output | CW (3) | Channel number of the latest event |

## Verification
If the sequencer's channel counter or word counter is wrong, the error appears within the same pass. The memory address stream skips or repeats a word, or leaves ascending order. Storage or masking faults show up at the next register read of the affected word. A branch bit that is not cleared shows up one frame later, when a second fetch goes to the branch target instead of the stored link. A window comparison that is off by one shows up at the first pass that uses a pointer or source address placed exactly on the window edge: an access is missing or extra, or a bus-error pulse is missing or extra.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  localparam logic [31:0] LINK_MASK   = 32'hFFFF_FFF0;
  localparam logic [31:0] BRANCH_MASK = 32'hFFFF_FFF3;
  localparam int BR_ACT = 0;
  localparam int BR_IRQ = 1;

  typedef enum logic [1:0] {
    DW_LINK = 2'd0,
    DW_SRC  = 2'd1,
    DW_ID   = 2'd2,
    DW_CMD  = 2'd3
  } dword_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEL   = 2'd1,
    ST_FETCH = 2'd2,
    ST_CHK   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/fdf_win.sv
module fdf_win #(
  parameter logic [31:0] BASE  = 32'h0000_1000,
  parameter logic [31:0] BYTES = 32'h0000_1000,
  parameter int          SPAN  = 16
) (
  input  logic [31:0] addr,
  output logic        ok
);
  localparam logic [32:0] LIMIT = {1'b0, BASE} + {1'b0, BYTES};
  logic [32:0] last_excl;

  always_comb begin
    last_excl = {1'b0, addr} + 33'(SPAN);
    ok = (addr >= BASE) && (last_excl <= LIMIT);
  end
endmodule

// File: rtl/fdf_regs.sv
module fdf_regs
  import fdf_pkg::*;
#(
  parameter int              NCH     = 7,
  parameter int              AW      = 12,
  parameter int              CW      = 3,
  parameter logic [AW-1:0]   CH_BASE = 12'h200,
  parameter logic [AW-1:0]   BR_BASE = 12'h100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_err,
  input  logic [CW-1:0] cur_ch,
  input  logic          upd_we,
  input  logic [1:0]    upd_word,
  input  logic [31:0]   upd_data,
  input  logic          src_clr,
  input  logic          bra_clr,
  output logic [31:0]   cur_link,
  output logic [31:0]   cur_src,
  output logic [31:0]   cur_br
);
  localparam logic [AW-1:0] NCH_A = AW'(NCH);

  logic [31:0] link_q [NCH];
  logic [31:0] src_q  [NCH];
  logic [31:0] id_q   [NCH];
  logic [31:0] cmd_q  [NCH];
  logic [31:0] br_q   [NCH];

  logic [AW-1:0] ch_off, br_off;
  logic          ch_hit, br_hit;
  logic [CW-1:0] ch_idx, br_idx;
  logic [1:0]    ch_word;

  always_comb begin
    ch_off  = reg_addr - CH_BASE;
    br_off  = reg_addr - BR_BASE;
    ch_hit  = (reg_addr >= CH_BASE) && (ch_off[1:0] == 2'b00) && ((ch_off >> 4) < NCH_A);
    br_hit  = (reg_addr >= BR_BASE) && (br_off[1:0] == 2'b00) && ((br_off >> 2) < NCH_A);
    ch_idx  = ch_off[4 +: CW];
    br_idx  = br_off[2 +: CW];
    ch_word = ch_off[3:2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        link_q[c] <= '0;
        src_q[c]  <= '0;
        id_q[c]   <= '0;
        cmd_q[c]  <= '0;
        br_q[c]   <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (reg_wr && ch_hit && ch_idx == CW'(c) && ch_word == DW_LINK)
          link_q[c] <= reg_wdata & LINK_MASK;
        if (src_clr && cur_ch == CW'(c))
          src_q[c] <= '0;
        if (upd_we && cur_ch == CW'(c)) begin
          case (upd_word)
            DW_LINK: link_q[c] <= upd_data;
            DW_SRC:  src_q[c]  <= upd_data;
            DW_ID:   id_q[c]   <= upd_data;
            default: cmd_q[c]  <= upd_data;
          endcase
        end
        if (bra_clr && cur_ch == CW'(c))
          br_q[c][BR_ACT] <= 1'b0;
        if (reg_wr && br_hit && br_idx == CW'(c))
          br_q[c] <= reg_wdata & BRANCH_MASK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      reg_err <= 1'b0;
      if (reg_rd) begin
        if (ch_hit) begin
          case (ch_word)
            DW_LINK: reg_rdata <= link_q[ch_idx];
            DW_SRC:  reg_rdata <= src_q[ch_idx];
            DW_ID:   reg_rdata <= id_q[ch_idx];
            default: reg_rdata <= cmd_q[ch_idx];
          endcase
        end else if (br_hit) begin
          reg_rdata <= br_q[br_idx];
        end else begin
          reg_rdata <= '0;
          reg_err   <= 1'b1;
        end
      end
    end
  end

  assign cur_link = link_q[cur_ch];
  assign cur_src  = src_q[cur_ch];
  assign cur_br   = br_q[cur_ch];

  AST_ERR_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    reg_err |-> $past(reg_rd)); // R3

  AST_BRANCH_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (bra_clr && !(reg_wr && br_hit && br_idx == cur_ch)) |=> !cur_br[BR_ACT]); // R6
endmodule

// File: rtl/fdf_seq.sv
module fdf_seq
  import fdf_pkg::*;
#(
  parameter int          NCH       = 7,
  parameter int          CW        = 3,
  parameter logic [31:0] WIN_BASE  = 32'h0000_1000,
  parameter logic [31:0] WIN_BYTES = 32'h0000_1000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_start,
  input  logic [NCH-1:0] chan_en,
  output logic           busy,
  output logic           frame_done,
  output logic           mem_req,
  output logic [31:0]    mem_addr,
  input  logic           mem_ack,
  input  logic [31:0]    mem_rdata,
  output logic           evt_bs,
  output logic           evt_ber,
  output logic [CW-1:0]  evt_chan,
  output logic [CW-1:0]  cur_ch,
  output logic           upd_we,
  output logic [1:0]     upd_word,
  output logic [31:0]    upd_data,
  output logic           src_clr,
  output logic           bra_clr,
  input  logic [31:0]    cur_link,
  input  logic [31:0]    cur_src,
  input  logic [31:0]    cur_br
);
  localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);
  localparam logic [32:0]   WIN_END = {1'b0, WIN_BASE} + {1'b0, WIN_BYTES};

  seq_state_e    state_q;
  logic [CW-1:0] ch_q;
  logic [1:0]    word_q;
  logic [31:0]   ptr;
  logic          ptr_ok, src_ok, ch_on;

  assign ch_on = chan_en[ch_q];
  assign ptr   = cur_br[BR_ACT] ? (cur_br & LINK_MASK) : cur_link;

  fdf_win #(.BASE(WIN_BASE), .BYTES(WIN_BYTES), .SPAN(16)) u_desc_win (
    .addr(ptr), .ok(ptr_ok));
  fdf_win #(.BASE(WIN_BASE), .BYTES(WIN_BYTES), .SPAN(1)) u_src_win (
    .addr(cur_src), .ok(src_ok));

  assign busy     = (state_q != ST_IDLE);
  assign mem_req  = (state_q == ST_FETCH);
  assign cur_ch   = ch_q;
  assign src_clr  = (state_q == ST_SEL);
  assign bra_clr  = (state_q == ST_SEL) && ch_on && cur_br[BR_ACT];
  assign upd_we   = (state_q == ST_FETCH) && mem_ack;
  assign upd_word = word_q;
  assign upd_data = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ch_q       <= '0;
      word_q     <= '0;
      mem_addr   <= '0;
      evt_bs     <= 1'b0;
      evt_ber    <= 1'b0;
      evt_chan   <= '0;
      frame_done <= 1'b0;
    end else begin
      evt_bs     <= 1'b0;
      evt_ber    <= 1'b0;
      frame_done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (frame_start) begin
            ch_q    <= '0;
            state_q <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (!ch_on) begin
            if (ch_q == LAST_CH) begin
              state_q    <= ST_IDLE;
              frame_done <= 1'b1;
            end else begin
              ch_q    <= ch_q + 1'b1;
              state_q <= ST_SEL;
            end
          end else begin
            if (cur_br[BR_ACT] && cur_br[BR_IRQ]) begin
              evt_bs   <= 1'b1;
              evt_chan <= ch_q;
            end
            if (ptr_ok) begin
              mem_addr <= ptr;
              word_q   <= '0;
              state_q  <= ST_FETCH;
            end else begin
              state_q <= ST_CHK;
            end
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            if (word_q == 2'd3) begin
              state_q <= ST_CHK;
            end else begin
              word_q   <= word_q + 1'b1;
              mem_addr <= mem_addr + 32'd4;
            end
          end
        end
        default: begin
          if (cur_src == 32'd0 || !src_ok) begin
            evt_ber  <= 1'b1;
            evt_chan <= ch_q;
          end
          if (ch_q == LAST_CH) begin
            state_q    <= ST_IDLE;
            frame_done <= 1'b1;
          end else begin
            ch_q    <= ch_q + 1'b1;
            state_q <= ST_SEL;
          end
        end
      endcase
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R4

  AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && cur_ch != $past(cur_ch)) |-> (cur_ch == CW'($past(cur_ch) + 1'b1))); // R5

  AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr >= WIN_BASE && {1'b0, mem_addr} + 33'd4 <= WIN_END)); // R8

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_bs, evt_ber})); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !busy); // R10
endmodule

// File: rtl/fdf_top.sv
module fdf_top #(
  parameter int          NCH       = 7,
  parameter int          AW        = 12,
  parameter logic [31:0] WIN_BASE  = 32'h0000_1000,
  parameter logic [31:0] WIN_BYTES = 32'h0000_1000,
  parameter int          CW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [AW-1:0]  reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           reg_err,
  input  logic [NCH-1:0] chan_en,
  input  logic           frame_start,
  output logic           busy,
  output logic           frame_done,
  output logic           mem_req,
  output logic [31:0]    mem_addr,
  input  logic           mem_ack,
  input  logic [31:0]    mem_rdata,
  output logic           evt_bs,
  output logic           evt_ber,
  output logic [CW-1:0]  evt_chan
);
  localparam logic [AW-1:0] CH_BASE = AW'(12'h200);
  localparam logic [AW-1:0] BR_BASE = AW'(12'h100);

  logic [CW-1:0] cur_ch;
  logic          upd_we, src_clr, bra_clr;
  logic [1:0]    upd_word;
  logic [31:0]   upd_data, cur_link, cur_src, cur_br;

  fdf_regs #(.NCH(NCH), .AW(AW), .CW(CW), .CH_BASE(CH_BASE), .BR_BASE(BR_BASE)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_err(reg_err),
    .cur_ch(cur_ch), .upd_we(upd_we), .upd_word(upd_word), .upd_data(upd_data),
    .src_clr(src_clr), .bra_clr(bra_clr),
    .cur_link(cur_link), .cur_src(cur_src), .cur_br(cur_br));

  fdf_seq #(.NCH(NCH), .CW(CW), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_seq (
    .clk(clk), .rst(rst), .frame_start(frame_start), .chan_en(chan_en),
    .busy(busy), .frame_done(frame_done),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .evt_bs(evt_bs), .evt_ber(evt_ber), .evt_chan(evt_chan),
    .cur_ch(cur_ch), .upd_we(upd_we), .upd_word(upd_word), .upd_data(upd_data),
    .src_clr(src_clr), .bra_clr(bra_clr),
    .cur_link(cur_link), .cur_src(cur_src), .cur_br(cur_br));
endmodule

// File: tb/sim_fdf_top.sv
`timescale 1ns/1ps
module sim_fdf_top;
  localparam int NCH = 7;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] WSZ  = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_err;
  logic [NCH-1:0] chan_en = '0;
  logic frame_start = 1'b0;
  logic busy, frame_done, mem_req, mem_ack, evt_bs, evt_ber;
  logic [31:0] mem_addr, mem_rdata;
  logic [2:0] evt_chan;

  always #2.5 clk = ~clk;

  fdf_top u0 (.clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err), .chan_en(chan_en),
    .frame_start(frame_start), .busy(busy), .frame_done(frame_done), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .evt_bs(evt_bs),
    .evt_ber(evt_ber), .evt_chan(evt_chan));

  int checks = 0, failures = 0;
  int cycles = 0;

  logic [31:0] mem [1024];
  int acc_n, bs_n, ber_n, done_n;
  logic [31:0] acc_addr [64];
  logic [2:0] bs_ch, ber_ch;

  // memory model: one-cycle acknowledge, logs the address stream
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem[(mem_addr - BASE) >> 2];
      if (acc_n < 64) acc_addr[acc_n] = mem_addr;
      acc_n = acc_n + 1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(negedge clk) begin
    cycles = cycles + 1;
    if (evt_bs)     begin bs_n = bs_n + 1;   bs_ch = evt_chan;  end
    if (evt_ber)    begin ber_n = ber_n + 1; ber_ch = evt_chan; end
    if (frame_done) done_n = done_n + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] dsc(input int c);  return BASE + 32'(c) * 32'h40; endfunction
  function automatic logic [31:0] bdsc(input int c); return 32'h1400 + 32'(c) * 32'h40; endfunction
  function automatic logic [31:0] srca(input int c); return 32'h1800 + 32'(c) * 32'h10; endfunction
  function automatic logic [31:0] fid(input int c);  return 32'hF1D0_0000 + 32'(c); endfunction
  function automatic logic [31:0] fcmd(input int c); return 32'h0460_0000 + 32'(c) * 4; endfunction

  task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, w1, w2, w3);
    mem[(a - BASE) >> 2]       = w0;
    mem[((a - BASE) >> 2) + 1] = w1;
    mem[((a - BASE) >> 2) + 2] = w2;
    mem[((a - BASE) >> 2) + 3] = w3;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input logic exp_err, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
    chk(reg_err == exp_err, {tag, " err"}, 32'(reg_err), 32'(exp_err));
  endtask

  function automatic logic [11:0] chreg(input int c, input int w);
    return 12'h200 + 12'(c * 16 + w * 4);
  endfunction
  function automatic logic [11:0] brreg(input int c); return 12'h100 + 12'(c * 4); endfunction

  task automatic run_frame(input logic [NCH-1:0] en, input bit dbl);
    @(negedge clk);
    chan_en = en;
    acc_n = 0; bs_n = 0; ber_n = 0; done_n = 0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", 32'(busy), 32'd1);
    if (dbl) begin
      repeat (3) @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
    end
    for (int t = 0; t < 2000 && busy; t++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    for (int c = 0; c < NCH; c++) begin
      put_desc(dsc(c), dsc(c), srca(c), fid(c), fcmd(c));
      put_desc(bdsc(c), dsc(c), srca(c) + 32'h4, 32'hB000_0000 + 32'(c), 32'h0040_0000 | 32'(c));
    end
    put_desc(32'h1FF0, 32'h1FF0, 32'h1FFC, 32'h0000_00E6, 32'h0);
    put_desc(32'h1600, 32'h1600, 32'h0,    32'h0000_0A01, 32'h0);
    put_desc(32'h1640, 32'h1640, 32'h2000, 32'h0000_0A02, 32'h0);
    put_desc(32'h1680, 32'h1680, 32'h1FFF, 32'h0000_0A03, 32'h0);
    acc_n = 0; bs_n = 0; ber_n = 0; done_n = 0; bs_ch = 0; ber_ch = 0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk(!busy && !mem_req && !frame_done && !evt_bs && !evt_ber, "R1 idle outputs",
        {27'd0, busy, mem_req, frame_done, evt_bs, evt_ber}, 32'd0);
    for (int c = 0; c < NCH; c += 6) begin
      for (int w = 0; w < 4; w++) rd(chreg(c, w), 32'd0, 1'b0, "R1 channel word");
      rd(brreg(c), 32'd0, 1'b0, "R1 branch");
    end

    // R2: write masks and read-only words
    wr(chreg(3, 0), 32'hFFFF_FFFF);
    rd(chreg(3, 0), 32'hFFFF_FFF0, 1'b0, "R2 link mask");
    wr(brreg(2), 32'hFFFF_FFFF);
    rd(brreg(2), 32'hFFFF_FFF3, 1'b0, "R2 branch mask");
    wr(chreg(3, 1), 32'h0000_1234);
    wr(chreg(3, 2), 32'h0000_5678);
    wr(chreg(3, 3), 32'h0000_9ABC);
    rd(chreg(3, 1), 32'd0, 1'b0, "R2 source read-only");
    rd(chreg(3, 2), 32'd0, 1'b0, "R2 id read-only");
    rd(chreg(3, 3), 32'd0, 1'b0, "R2 cmd read-only");
    wr(brreg(2), 32'd0);

    // R3: unmapped offsets
    rd(12'h000, 32'd0, 1'b1, "R3 offset 000");
    rd(12'h202, 32'd0, 1'b1, "R3 misaligned");
    rd(12'h270, 32'd0, 1'b1, "R3 channel past end");
    rd(12'h11C, 32'd0, 1'b1, "R3 branch past end");
    rd(12'hFFC, 32'd0, 1'b1, "R3 top offset");

    // R4 / R5: enable pattern sweep
    for (int c = 0; c < NCH; c++) wr(chreg(c, 0), dsc(c));
    begin
      logic [NCH-1:0] pats [6];
      pats[0] = 7'h7F; pats[1] = 7'h55; pats[2] = 7'h2A;
      pats[3] = 7'h40; pats[4] = 7'h01; pats[5] = 7'h00;
      for (int p = 0; p < 6; p++) begin
        int k;
        run_frame(pats[p], 1'b0);
        k = 0;
        for (int c = 0; c < NCH; c++) begin
          if (pats[p][c]) begin
            for (int w = 0; w < 4; w++) begin
              chk(k < 64 && acc_addr[k] == dsc(c) + 32'(w * 4), "R5 access order",
                  (k < 64) ? acc_addr[k] : 32'hFFFF_FFFF, dsc(c) + 32'(w * 4));
              k++;
            end
            rd(chreg(c, 0), dsc(c),  1'b0, "R4 link stored");
            rd(chreg(c, 1), srca(c), 1'b0, "R4 source stored");
            rd(chreg(c, 2), fid(c),  1'b0, "R4 id stored");
            rd(chreg(c, 3), fcmd(c), 1'b0, "R4 cmd stored");
          end else begin
            rd(chreg(c, 1), 32'd0, 1'b0, "R5 disabled source cleared");
          end
        end
        chk(acc_n == 4 * $countones(pats[p]), "R5 access count", 32'(acc_n), 32'(4 * $countones(pats[p])));
        chk(ber_n == 0 && bs_n == 0, "R9 no events", 32'(ber_n + bs_n), 32'd0);
        chk(done_n == 1 && !busy, "R10 single done", 32'(done_n), 32'd1);
      end
    end

    // R10: start while busy is ignored
    run_frame(7'h7F, 1'b1);
    chk(done_n == 1, "R10 second start ignored (done)", 32'(done_n), 32'd1);
    chk(acc_n == 28, "R10 second start ignored (accesses)", 32'(acc_n), 32'd28);

    // R6: branch without interrupt
    wr(brreg(1), bdsc(1) | 32'h1);
    run_frame(7'h02, 1'b0);
    chk(acc_addr[0] == bdsc(1), "R6 branch target used", acc_addr[0], bdsc(1));
    rd(chreg(1, 2), 32'hB000_0001, 1'b0, "R6 branch id");
    rd(chreg(1, 1), srca(1) + 32'h4, 1'b0, "R6 branch source");
    rd(chreg(1, 0), dsc(1), 1'b0, "R6 branch link");
    rd(brreg(1), bdsc(1), 1'b0, "R6 active bit cleared");
    chk(bs_n == 0, "R7 no event without irq bit", 32'(bs_n), 32'd0);
    run_frame(7'h02, 1'b0);
    chk(acc_addr[0] == dsc(1), "R6 one-shot back to link", acc_addr[0], dsc(1));
    rd(chreg(1, 2), fid(1), 1'b0, "R6 link id again");

    // R7: branch with interrupt
    wr(brreg(4), bdsc(4) | 32'h3);
    run_frame(7'h10, 1'b0);
    chk(bs_n == 1 && bs_ch == 3'd4, "R7 branch event ch4", {bs_ch, 8'(bs_n)}, {3'd4, 8'd1});
    rd(brreg(4), bdsc(4) | 32'h2, 1'b0, "R7 irq bit kept");
    run_frame(7'h10, 1'b0);
    chk(bs_n == 0, "R7 irq bit alone silent", 32'(bs_n), 32'd0);
    chk(acc_addr[0] == dsc(4), "R7 irq bit alone uses link", acc_addr[0], dsc(4));
    wr(brreg(4), 32'h0000_3000 | 32'h3);
    run_frame(7'h10, 1'b0);
    chk(bs_n == 1 && ber_n == 1 && ber_ch == 3'd4, "R7 event before rejection",
        {ber_ch, 4'(bs_n), 4'(ber_n)}, {3'd4, 4'd1, 4'd1});
    chk(acc_n == 0, "R8 rejected branch target not read", 32'(acc_n), 32'd0);

    // R8: descriptor window edges
    wr(chreg(6, 0), 32'h1FF0);
    run_frame(7'h40, 1'b0);
    chk(acc_n == 4 && ber_n == 0, "R8 top-edge descriptor fetched", 32'(acc_n), 32'd4);
    rd(chreg(6, 2), 32'hE6, 1'b0, "R8 top-edge id");
    wr(chreg(6, 0), 32'h2000);
    run_frame(7'h40, 1'b0);
    chk(acc_n == 0, "R8 past-end skipped", 32'(acc_n), 32'd0);
    rd(chreg(6, 1), 32'd0, 1'b0, "R8 skipped source zero");
    rd(chreg(6, 2), 32'hE6, 1'b0, "R8 skipped id kept");
    chk(ber_n == 1 && ber_ch == 3'd6, "R9 skipped gives bus error ch6", {29'd0, ber_ch}, 32'd6);
    wr(chreg(6, 0), 32'h0FF0);
    run_frame(7'h40, 1'b0);
    chk(acc_n == 0 && ber_n == 1, "R8 below-base skipped", 32'(acc_n), 32'd0);

    // R9: source checks
    wr(chreg(3, 0), 32'h1600);
    run_frame(7'h08, 1'b0);
    chk(ber_n == 1 && ber_ch == 3'd3, "R9 zero source ch3", {29'd0, ber_ch}, 32'd3);
    wr(chreg(3, 0), 32'h1640);
    run_frame(7'h08, 1'b0);
    chk(ber_n == 1 && ber_ch == 3'd3, "R9 source at window end", 32'(ber_n), 32'd1);
    wr(chreg(3, 0), 32'h1680);
    run_frame(7'h08, 1'b0);
    chk(ber_n == 0, "R9 last in-window source accepted", 32'(ber_n), 32'd0);
    rd(chreg(3, 1), 32'h1FFF, 1'b0, "R9 source stored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule